// File: doc/BRIEF.md
# Exception Restart Address Capture

This block keeps the restart address that a pipeline needs once it takes an exception, together with a flag that tells the handler the faulting instruction sat in the slot after a branch or jump. On every clock the pipeline presents the address of the instruction at the exception point, a flag saying whether the instruction before it was a control transfer, and a five-bit cause code. When the exception strobe is high, the block records these values. If the faulting instruction follows a branch or jump, the restart address is backed up by one instruction so that it points at that branch or jump, and the delay flag is set. Otherwise the restart address is the faulting address and the flag is cleared.

Whether an instruction counts as a delay-slot instruction depends only on the previous instruction being a branch or jump. A taken/not-taken input is accepted for interface compatibility and has no effect on either register. The recorded restart address drives a dedicated return-address output that the return-from-exception path uses. Software reads both registers through an indexed read port.

Top module: `exc_pc_capture`

## Requirements
- R1: After reset, the restart-address register and the cause register both read as zero, and the return-address output is zero.
- R2: When the strobe is high and the previous-was-branch flag is low, the next clock stores the faulting address unchanged as the restart address, and clears the delay flag.
- R3: When the strobe is high and the previous-was-branch flag is high, the next clock stores the faulting address minus 4 (one 4-byte instruction back) as the restart address.
- R4: When the strobe is high, the delay flag (cause register bit 31) takes the value of the previous-was-branch flag.
- R5: The branch-taken input has no effect: a delay-slot exception after an untaken branch gives the same restart address and delay flag as one after a taken branch.
- R6: While the strobe is low, the restart address, delay flag and cause code keep their values, whatever the other inputs do.
- R7: The five-bit cause code input is stored in cause register bits 6 down to 2 on the same edge that the restart address is stored. All other cause bits except bit 31 read zero.
- R8: The read port is combinational. Index 0 returns the restart-address register, index 1 returns the cause register, and indices 2 and 3 return zero.
- R9: The return-address output always equals the stored restart-address register.
- R10: The back-up wraps modulo 2^32, so a delay-slot exception at address 0 records 0xFFFFFFFC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| excStrobe | input | 1 | Exception taken this cycle |
| faultPc | input | 32 | Address of the instruction at the exception point |
| prevWasBranch | input | 1 | The previous instruction was a branch or jump |
| prevTaken | input | 1 | The previous branch was taken (ignored) |
| causeCode | input | 5 | Exception cause code to record |
| rdIdx | input | 2 | Register-read index |
| rdData | output | 32 | Register-read data |
| retPc | output | 32 | Stored restart address, used for return-from-exception |

## Verification
The assertions assume that the inputs are known whenever reset is released. They also assume that the faulting address and the branch flag are valid in any cycle where the strobe is high, because the back-up check compares against the previous cycle's address. The stimulus drives every input to a defined value on the falling edge, outside reset. It mixes directed exceptions, including taken, untaken and non-branch cases and the zero-address wrap, with long stretches of strobe-low cycles in which the address, flags, code and read index keep changing, so that the hold behaviour is exercised against busy inputs.

// File: rtl/exc_pkg.sv
package exc_pkg;
  // Strobes passed from control to datapath.
  typedef struct packed {
    logic capture;   // load restart address and cause this edge
    logic inDelay;   // faulting instruction sits after a branch/jump
  } excCtl_t;
endpackage

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
(
  input  logic    excStrobe,
  input  logic    prevWasBranch,
  output excCtl_t ctl
);
  // Delay-slot labelling is static: only the kind of the previous
  // instruction matters, never its outcome.
  always_comb begin
    ctl.capture = excStrobe;
    ctl.inDelay = excStrobe & prevWasBranch;
  end
endmodule

// File: rtl/exc_datapath.sv
module exc_datapath
  import exc_pkg::*;
#(
  parameter int PC_W        = 32,
  parameter int CODE_W      = 5,
  parameter int IDX_W       = 2,
  parameter int INSTR_BYTES = 4,
  parameter int BD_POS      = 31,
  parameter int CODE_LSB    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  excCtl_t           ctl,
  input  logic [PC_W-1:0]   faultPc,
  input  logic [CODE_W-1:0] causeCode,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [PC_W-1:0]   rdData,
  output logic [PC_W-1:0]   epcOut,
  output logic              bdOut,
  output logic [CODE_W-1:0] codeOut
);
  localparam logic [PC_W-1:0]  STEP    = PC_W'(INSTR_BYTES);
  localparam logic [IDX_W-1:0] IDX_EPC = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_CAU = IDX_W'(1);

  logic [PC_W-1:0]   epcQ, epcNext, causeWord;
  logic              bdQ;
  logic [CODE_W-1:0] codeQ;

  always_comb epcNext = ctl.inDelay ? (faultPc - STEP) : faultPc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      epcQ  <= '0;
      bdQ   <= 1'b0;
      codeQ <= '0;
    end else if (ctl.capture) begin
      epcQ  <= epcNext;
      bdQ   <= ctl.inDelay;
      codeQ <= causeCode;
    end
  end

  always_comb begin
    causeWord = '0;
    causeWord[BD_POS] = bdQ;
    causeWord[CODE_LSB +: CODE_W] = codeQ;
  end

  always_comb begin
    case (rdIdx)
      IDX_EPC: rdData = epcQ;
      IDX_CAU: rdData = causeWord;
      default: rdData = '0;
    endcase
  end

  assign epcOut  = epcQ;
  assign bdOut   = bdQ;
  assign codeOut = codeQ;

  // R6: registers hold without a capture strobe
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> ($stable(epcQ) && $stable(bdQ) && $stable(codeQ)));

  // R7: cause code recorded on capture
  a_r7_code_latch: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> (codeQ == $past(causeCode)));
endmodule

// File: rtl/exc_pc_capture.sv
module exc_pc_capture
  import exc_pkg::*;
#(
  parameter int PC_W        = 32,
  parameter int CODE_W      = 5,
  parameter int IDX_W       = 2,
  parameter int INSTR_BYTES = 4,
  parameter int BD_POS      = 31,
  parameter int CODE_LSB    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              excStrobe,
  input  logic [PC_W-1:0]   faultPc,
  input  logic              prevWasBranch,
  input  logic              prevTaken,
  input  logic [CODE_W-1:0] causeCode,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [PC_W-1:0]   rdData,
  output logic [PC_W-1:0]   retPc
);
  localparam logic [PC_W-1:0] STEP = PC_W'(INSTR_BYTES);

  excCtl_t           ctl;
  logic              bdNow;
  logic [CODE_W-1:0] codeNow;

  exc_ctrl uCtrl (
    .excStrobe     (excStrobe),
    .prevWasBranch (prevWasBranch),
    .ctl           (ctl)
  );

  exc_datapath #(
    .PC_W(PC_W), .CODE_W(CODE_W), .IDX_W(IDX_W),
    .INSTR_BYTES(INSTR_BYTES), .BD_POS(BD_POS), .CODE_LSB(CODE_LSB)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .faultPc   (faultPc),
    .causeCode (causeCode),
    .rdIdx     (rdIdx),
    .rdData    (rdData),
    .epcOut    (retPc),
    .bdOut     (bdNow),
    .codeOut   (codeNow)
  );

  // R2: plain exception keeps the faulting address, flag cleared
  a_r2_plain_epc: assert property (@(posedge clk) disable iff (!rstN)
    (excStrobe && !prevWasBranch) |=> (retPc == $past(faultPc) && !bdNow));

  // R3: delay-slot exception backs up one instruction
  a_r3_backup_epc: assert property (@(posedge clk) disable iff (!rstN)
    (excStrobe && prevWasBranch) |=> (retPc == $past(faultPc) - STEP));

  // R4: delay flag follows the previous-was-branch flag
  a_r4_bd_flag: assert property (@(posedge clk) disable iff (!rstN)
    excStrobe |=> (bdNow == $past(prevWasBranch)));

  // R5: untaken branch still labels the next instruction as delay slot
  a_r5_untaken_delay: assert property (@(posedge clk) disable iff (!rstN)
    (excStrobe && prevWasBranch && !prevTaken) |=> bdNow);

  // R8: unused read indices return zero
  a_r8_unused_idx: assert property (@(posedge clk) disable iff (!rstN)
    (rdIdx > IDX_W'(1)) |-> (rdData == '0));
endmodule

// File: tb/exc_pc_capture_test.sv
`timescale 1ns/1ps
module exc_pc_capture_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        excStrobe = 1'b0;
  logic [31:0] faultPc = '0;
  logic        prevWasBranch = 1'b0;
  logic        prevTaken = 1'b0;
  logic [4:0]  causeCode = '0;
  logic [1:0]  rdIdx = '0;
  logic [31:0] rdData, retPc;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  // reference state
  logic [31:0] refEpc = '0;
  bit          refBd = 0;
  logic [4:0]  refCode = '0;

  always #2.5 clk = ~clk;

  exc_pc_capture uut (
    .clk(clk), .rstN(rstN), .excStrobe(excStrobe), .faultPc(faultPc),
    .prevWasBranch(prevWasBranch), .prevTaken(prevTaken),
    .causeCode(causeCode), .rdIdx(rdIdx), .rdData(rdData), .retPc(retPc)
  );

  function automatic logic [31:0] expRead(input logic [1:0] idx);
    case (idx)
      2'd0: return refEpc;
      2'd1: return {refBd, 24'd0, refCode, 2'b00};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic step(input string req, input bit s, input logic [31:0] pc,
                      input bit br, input bit tk, input logic [4:0] code,
                      input logic [1:0] idx);
    excStrobe = s; faultPc = pc; prevWasBranch = br; prevTaken = tk;
    causeCode = code; rdIdx = idx;
    @(posedge clk);
    if (s) begin
      refEpc  = br ? pc - 32'd4 : pc;
      refBd   = br;
      refCode = code;
    end
    @(negedge clk);
    check({req, " read"}, rdData, expRead(idx));
    check("R9 retPc", retPc, refEpc);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 retPc in reset", retPc, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    rdIdx = 2'd0; #0.1; check("R1 epc after reset", rdData, 32'd0);
    rdIdx = 2'd1; #0.1; check("R1 cause after reset", rdData, 32'd0);

    // R2 / R7: plain exception
    step("R2 plain", 1, 32'h0000_1000, 0, 0, 5'd7, 2'd0);
    step("R7 code", 0, 32'h1234_5678, 1, 1, 5'd3, 2'd1);
    // R3 / R4: delay slot after taken branch
    step("R3 backup", 1, 32'h0000_2008, 1, 1, 5'd12, 2'd0);
    step("R4 bd set", 0, 32'h0, 0, 0, 5'd0, 2'd1);
    // R2 / R4: flag cleared again
    step("R2 plain again", 1, 32'h8000_0040, 0, 1, 5'd31, 2'd1);
    // R5: untaken branch same as taken
    step("R5 untaken", 1, 32'h0000_3004, 1, 0, 5'd2, 2'd0);
    step("R5 untaken bd", 0, 32'hFFFF_FFFF, 0, 1, 5'd9, 2'd1);
    // R6: hold with busy inputs
    for (int i = 0; i < 8; i++)
      step("R6 hold", 0, 32'hA5A5_0000 + i, i[0], i[1], 5'(i), 2'(i));
    // R8: unused indices
    step("R8 idx2", 0, 32'h0, 0, 0, 5'd0, 2'd2);
    step("R8 idx3", 0, 32'h0, 1, 1, 5'd1, 2'd3);
    // R10: wrap at address zero
    step("R10 wrap", 1, 32'h0, 1, 0, 5'd4, 2'd0);
    step("R10 wrap cause", 0, 32'h0, 0, 0, 5'd0, 2'd1);

    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      bit s;
      s = ($urandom % 5) == 0;
      step(s ? "R2 R3 R4 mixed" : "R6 mixed", s, $urandom & 32'hFFFF_FFFC,
           1'($urandom), 1'($urandom), 5'($urandom), 2'($urandom));
    end

    finish_run();
  end
endmodule